// File: doc/BRIEF.md
# Register LIFO Stack With Flags

This block is a last-in, first-out store of 64 words. Its slots are chosen by a 6-bit stack pointer that wraps modulo 64. A write stream pushes words onto the stack. A read-request stream pops the top word, which comes back on a registered output one cycle later. Two flags, `full` and `empty`, report the stack's state. Both come only from the pointer wrapping back to zero: a push that brings the pointer to zero marks the stack full, and a pop that brings it to zero marks it empty.

A push first advances the pointer and then writes the word into the slot at the new pointer. The first word therefore lands in slot 1 and the 64th word in slot 0. A pop reads the slot at the current pointer and then steps the pointer back. Both request channels use valid/ready handshakes. `push_ready` is high exactly when the stack is not full, and `pop_ready` is high exactly when it is not empty. Each ready depends only on the flags, never on the other channel's valid. A source may hold `valid` until it sees `ready`.

Some requests cannot be carried out: a push into a full stack, a pop from an empty stack, or a push and a pop raised in the same cycle. Any such request is dropped. It leaves the pointer, the flags and the stored words unchanged, and it raises `req_error` for one cycle. The popped-word output has no back-pressure, so the consumer must take `pop_data` in the cycle `pop_data_valid` is high.

Top module: `lifo_reg_stack`

## Requirements
- R1: After reset, `stack_ptr` is 0, `empty` is 1, `full` is 0, and `req_error` and `pop_data_valid` are 0.
- R2: An accepted push (`push_valid` high, `pop_valid` low, `full` low) increments `stack_ptr` by one modulo 64 at the clock edge, stores `push_data` in the slot at the new pointer, and clears `empty`.
- R3: `full` becomes 1 only when an accepted push wraps `stack_ptr` to 0, which is the 64th push from empty. That 64th word is held in slot 0. `full` and `empty` are never 1 together.
- R4: An accepted pop (`pop_valid` high, `push_valid` low, `empty` low) presents the word in the slot at the current `stack_ptr` on `pop_data`, with `pop_data_valid` high, in the cycle after the request. At the same edge, `stack_ptr` decrements by one modulo 64.
- R5: `empty` becomes 1 when an accepted pop brings `stack_ptr` to 0, and any accepted pop clears `full`.
- R6: Words come back in the reverse of the order they were pushed, including across a full 64-word fill and drain.
- R7: A push while `full` is 1 is ignored: `stack_ptr`, the flags and the stored words are unchanged. `req_error` is 1 for exactly the next cycle.
- R8: A pop while `empty` is 1 is ignored. `pop_data_valid` stays 0 and `req_error` is 1 for the next cycle.
- R9: When `push_valid` and `pop_valid` are both 1 in the same cycle, neither operation is performed, and `req_error` is 1 for the next cycle.
- R10: `push_ready` equals the inverse of `full`, and `pop_ready` equals the inverse of `empty`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request |
| push_ready | output | 1 | Stack can accept a push |
| push_data | input | DATA_W | Word to push |
| pop_valid | input | 1 | Pop request |
| pop_ready | output | 1 | Stack can serve a pop |
| pop_data | output | DATA_W | Popped word, registered |
| pop_data_valid | output | 1 | `pop_data` holds a fresh popped word this cycle |
| stack_ptr | output | PTR_W | Current stack pointer |
| full | output | 1 | Stack holds 64 words |
| empty | output | 1 | Stack holds no word |
| req_error | output | 1 | One-cycle pulse after a dropped request |

## Verification
The results arrive at different times. `stack_ptr`, `full`, `empty`, `req_error` and `pop_data_valid`/`pop_data` all change at the first rising edge after a request. The two ready outputs follow the flags with no clock in between. The bench drives each request half a period before the edge and checks the ready outputs against its model while the request is still applied. It then samples every registered output 2 ns after that edge, before the next request is driven. This lets a reference queue check every cycle's one-edge latency, including the single-cycle width of `req_error` and the absence of `pop_data_valid` on dropped pops.

// File: rtl/lifo_stack_pkg.sv
package lifo_stack_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BAD  = 2'd3
  } stk_op_e;
endpackage

// File: rtl/lifo_req_arbiter.sv
module lifo_req_arbiter
  import lifo_stack_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push_valid,
  input  logic    pop_valid,
  input  logic    full,
  input  logic    empty,
  output stk_op_e op,
  output logic    err_pulse
);
  // Decide which operation, if any, this cycle's requests produce.
  always_comb begin
    op = OP_NONE;
    if (push_valid && pop_valid)
      op = OP_BAD;
    else if (push_valid)
      op = full ? OP_BAD : OP_PUSH;
    else if (pop_valid)
      op = empty ? OP_BAD : OP_POP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_pulse <= 1'b0;
    else        err_pulse <= (op == OP_BAD);
  end
endmodule

// File: rtl/lifo_ptr_flags.sv
module lifo_ptr_flags
  import lifo_stack_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  output logic [PTR_W-1:0] sp,
  output logic [PTR_W-1:0] sp_next_up,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] sp_next_dn;

  assign sp_next_up = sp + PTR_W'(1);
  assign sp_next_dn = sp - PTR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp    <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      case (op)
        OP_PUSH: begin
          sp    <= sp_next_up;
          full  <= (sp_next_up == '0);
          empty <= 1'b0;
        end
        OP_POP: begin
          sp    <= sp_next_dn;
          empty <= (sp_next_dn == '0);
          full  <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lifo_word_store.sv
module lifo_word_store #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= slots[rd_addr];
    end
  end
endmodule

// File: rtl/lifo_reg_stack.sv
module lifo_reg_stack
  import lifo_stack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_valid,
  output logic              pop_ready,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_data_valid,
  output logic [PTR_W-1:0]  stack_ptr,
  output logic              full,
  output logic              empty,
  output logic              req_error
);
  stk_op_e          op;
  logic [PTR_W-1:0] sp_up;

  lifo_req_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_valid  (pop_valid),
    .full       (full),
    .empty      (empty),
    .op         (op),
    .err_pulse  (req_error)
  );

  lifo_ptr_flags #(.PTR_W(PTR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .sp         (stack_ptr),
    .sp_next_up (sp_up),
    .full       (full),
    .empty      (empty)
  );

  lifo_word_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (op == OP_PUSH),
    .wr_addr  (sp_up),
    .wr_data  (push_data),
    .rd_en    (op == OP_POP),
    .rd_addr  (stack_ptr),
    .rd_data  (pop_data),
    .rd_valid (pop_data_valid)
  );

  assign push_ready = ~full;
  assign pop_ready  = ~empty;
endmodule

// File: rtl/lifo_reg_stack_chk.sv
module lifo_reg_stack_chk #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             pop_valid,
  input logic             pop_data_valid,
  input logic [PTR_W-1:0] stack_ptr,
  input logic             full,
  input logic             empty,
  input logic             req_error
);
  logic push_ok, pop_ok;
  assign push_ok = push_valid && !pop_valid && !full;
  assign pop_ok  = pop_valid && !push_valid && !empty;

  assert_ptr_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (stack_ptr == PTR_W'($past(stack_ptr) + 1'b1)) && !empty);

  assert_full_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && (stack_ptr == '1)) |=> full);

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_pop_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> pop_data_valid && (stack_ptr == PTR_W'($past(stack_ptr) - 1'b1)));

  assert_empty_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && (stack_ptr == PTR_W'(1))) |=> empty && !full);

  assert_push_full_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !pop_valid && full) |=> $stable(stack_ptr) && full && req_error);

  assert_pop_empty_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !push_valid && empty) |=> $stable(stack_ptr) && !pop_data_valid && req_error);

  assert_both_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_valid) |=> $stable(stack_ptr) && !pop_data_valid && req_error);

  assert_no_error_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok || pop_ok || (!push_valid && !pop_valid)) |=> !req_error);
endmodule

bind lifo_reg_stack lifo_reg_stack_chk #(.PTR_W(PTR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .push_valid     (push_valid),
  .pop_valid      (pop_valid),
  .pop_data_valid (pop_data_valid),
  .stack_ptr      (stack_ptr),
  .full           (full),
  .empty          (empty),
  .req_error      (req_error)
);

// File: tb/tb_lifo_reg_stack.sv
`timescale 1ns/1ps
module tb_lifo_reg_stack;
  localparam int DW = 8;
  localparam int PW = 6;
  localparam int CAP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0, pop_valid = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic push_ready, pop_ready, pop_data_valid, full, empty, req_error;
  logic [DW-1:0] pop_data;
  logic [PW-1:0] stack_ptr;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int model_q[$];
  int lcg = 32'h1234;

  always #4 clk = ~clk;

  lifo_reg_stack #(.DATA_W(DW), .PTR_W(PW)) dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_data(pop_data), .pop_data_valid(pop_data_valid),
    .stack_ptr(stack_ptr), .full(full), .empty(empty), .req_error(req_error)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      finish_run();
    end
  end

  // One request cycle against the reference queue.
  task automatic step(input bit pu, input bit po, input int d);
    bit exp_err, exp_pv;
    int exp_pd, sz;
    @(negedge clk);
    push_valid = pu;
    pop_valid  = po;
    push_data  = DW'(d);
    #1;
    sz = model_q.size();
    check(push_ready == (sz != CAP), "R10", "push_ready", push_ready, sz != CAP);
    check(pop_ready == (sz != 0), "R10", "pop_ready", pop_ready, sz != 0);
    exp_err = 0; exp_pv = 0; exp_pd = 0;
    if (pu && po) exp_err = 1;
    else if (pu) begin
      if (sz == CAP) exp_err = 1;
      else model_q.push_back(d & 8'hFF);
    end else if (po) begin
      if (sz == 0) exp_err = 1;
      else begin exp_pd = model_q.pop_back(); exp_pv = 1; end
    end
    @(posedge clk);
    #2;
    push_valid = 0;
    pop_valid  = 0;
    sz = model_q.size();
    check(stack_ptr == PW'(sz % CAP), "R2", "stack_ptr", stack_ptr, sz % CAP);
    check(full == (sz == CAP), "R3", "full", full, sz == CAP);
    check(empty == (sz == 0), "R5", "empty", empty, sz == 0);
    check(req_error == exp_err, pu && po ? "R9" : (pu ? "R7" : "R8"),
          "req_error", req_error, exp_err);
    check(pop_data_valid == exp_pv, "R4", "pop_data_valid", pop_data_valid, exp_pv);
    if (exp_pv)
      check(pop_data == DW'(exp_pd), "R6", "pop_data", pop_data, exp_pd);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(stack_ptr == 0, "R1", "stack_ptr", stack_ptr, 0);
    check(empty == 1, "R1", "empty", empty, 1);
    check(full == 0, "R1", "full", full, 0);
    check(req_error == 0, "R1", "req_error", req_error, 0);
    check(pop_data_valid == 0, "R1", "pop_data_valid", pop_data_valid, 0);
    @(negedge clk) rst_n = 1'b1;

    // R8: pop from empty
    step(0, 1, 0);
    step(0, 0, 0);            // error pulse lasts one cycle (R8)
    // R2/R4/R6: short pushes and pops
    for (int i = 0; i < 5; i++) step(1, 0, 8'h10 + i);
    step(0, 1, 0);
    step(0, 1, 0);
    // R9: simultaneous requests
    step(1, 1, 8'hEE);
    step(0, 0, 0);
    // R5: drain to empty, then one extra pop
    for (int i = 0; i < 4; i++) step(0, 1, 0);
    // R3: fill all 64, then a push into the full stack (R7)
    for (int i = 0; i < CAP; i++) step(1, 0, 8'h40 + i);
    step(1, 0, 8'hAA);
    step(1, 1, 8'hBB);
    // R6: drain all 64 in reverse order, the first word coming from slot 0
    for (int i = 0; i < CAP; i++) step(0, 1, 0);
    step(0, 1, 0);
    // Mixed pattern
    for (int i = 0; i < 400; i++) begin
      lcg = lcg * 1103515245 + 12345;
      step(lcg[16], lcg[17] & lcg[18], (lcg >> 8) & 8'hFF);
    end
    finish_run();
  end
endmodule